// File: doc/BRIEF.md
# Interrupt Cause Bank

The block gathers up to 32 hardware event sources into one interrupt line. Each single-cycle event pulse sets a sticky cause bit. A mask, reset to all ones, chooses which pending causes may drive the interrupt output. Software changes the mask through two write-only ports: one sets mask bits and the other clears them. No read-modify-write is needed, so two agents can change different bits without a race.

Software chooses how causes are acknowledged by writing a 32-bit mode register at run time:
- With all ones in the mode register, a read of the cause register clears every bit that the read returned.
- With zero in the mode register, reads leave the causes alone and a write clears each bit written as 1.
- With any other mode value the causes stay set until the mode changes.

The register port is a plain single-cycle interface. Read data is combinational in the cycle of the strobe, and writes and read side effects take place at the clock edge that closes that cycle. This block carries no data stream, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset, cause reads 0, mask reads all ones, mode reads all ones and irq_o is 0.
- R2: A 1 on evt_i[k] sets cause bit k at the next clock edge, and the bit stays set until an acknowledge described in R5 or R6 clears it.
- R3: A write to address 3 (mask-set) sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Writing all ones masks every source.
- R4: A write to address 4 (mask-clear) clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: When mode is all ones, a read of address 0 returns the cause bits and clears all of the returned bits. In this mode a write to address 0 has no effect.
- R6: When mode is zero, a read of address 0 does not change the causes, and a write to address 0 clears exactly the bits written as 1.
- R7: When mode holds any value other than all zeros or all ones, neither reads nor writes of address 0 clear any cause bit.
- R8: If an event and a clear of the same bit fall in the same cycle, the bit is set after the edge.
- R9: Address 1 reads cause AND NOT mask, and address 2 reads the mask, both without side effects. Address 5 is the mode register and can be read and written.
- R10: irq_o is a register. It is 1 in the cycle after any cause bit is set while its mask bit is 0, and 0 in the cycle after no such bit exists.
- R11: Reads of addresses 6 and 7 return 0, and writes to them change no state.
- R12: A masked event is still recorded in the cause register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NBITS | Event pulses, one per cause bit |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, which triggers clear-on-read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | NBITS | Write data |
| bus_rdata_o | output | NBITS | Read data, combinational from the address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An event pulse can land on a cause bit in the same cycle that software acknowledges that bit. This can happen through a clear-on-read access or through a write-1-to-clear access. The bench provokes both cases by driving the event and the bus strobe on one falling edge. In the clear-on-read case it checks that the colliding read still returns the bit. In both cases a later read must show that the bit survived, and in the clear-on-read case a second read must then show it cleared.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CAUSE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MSET   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_MCLR   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd5;

  typedef struct packed {
    logic rd_cause;
    logic wr_cause;
    logic wr_mset;
    logic wr_mclr;
    logic wr_mode;
  } bus_strb_t;
endpackage

// File: rtl/irq_cause_bits.sv
module irq_cause_bits #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] evt_i,
  input  logic [NBITS-1:0] clr_i,
  output logic [NBITS-1:0] cause_o
);
  // One sticky cell per source; an event dominates a clear (R8)
  for (genvar k = 0; k < NBITS; k++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cause_o[k] <= 1'b0;
      else if (evt_i[k])  cause_o[k] <= 1'b1;
      else if (clr_i[k])  cause_o[k] <= 1'b0;
    end
  end

  // R2, R8: every pulsed bit is set after the edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((cause_o & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_mask_bits.sv
module irq_mask_bits #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic             clr_en_i,
  input  logic [NBITS-1:0] wdata_i,
  output logic [NBITS-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_o <= '1;
    else if (set_en_i) mask_o <= mask_o | wdata_i;
    else if (clr_en_i) mask_o <= mask_o & ~wdata_i;
  end

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en_i |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((mask_o & $past(wdata_i)) == '0));
  a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en_i || clr_en_i) |=> ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_cause_pkg::*;
#(
  parameter int NBITS = 32
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBITS-1:0]  cause_i,
  input  logic [NBITS-1:0]  mask_i,
  input  logic [NBITS-1:0]  mode_i,
  output bus_strb_t         strb_o,
  output logic [NBITS-1:0]  rdata_o
);
  always_comb begin
    strb_o          = '0;
    strb_o.rd_cause = rd_i && (addr_i == ADR_CAUSE);
    strb_o.wr_cause = wr_i && (addr_i == ADR_CAUSE);
    strb_o.wr_mset  = wr_i && (addr_i == ADR_MSET);
    strb_o.wr_mclr  = wr_i && (addr_i == ADR_MCLR);
    strb_o.wr_mode  = wr_i && (addr_i == ADR_MODE);
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_CAUSE:  rdata_o = cause_i;
      ADR_MASKED: rdata_o = cause_i & ~mask_i;
      ADR_MASK:   rdata_o = mask_i;
      ADR_MODE:   rdata_o = mode_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int NBITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBITS-1:0]  evt_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NBITS-1:0]  bus_wdata_i,
  output logic [NBITS-1:0]  bus_rdata_o,
  output logic              irq_o
);
  bus_strb_t        strb;
  logic [NBITS-1:0] cause_q;
  logic [NBITS-1:0] mask_q;
  logic [NBITS-1:0] mode_q;
  logic [NBITS-1:0] clr_vec;
  logic             cor_mode;
  logic             w1c_mode;

  irq_bus_decode #(.NBITS(NBITS)) u_dec (
    .wr_i(bus_wr_i), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .cause_i(cause_q), .mask_i(mask_q), .mode_i(mode_q),
    .strb_o(strb), .rdata_o(bus_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= '1;
    else if (strb.wr_mode) mode_q <= bus_wdata_i;
  end

  assign cor_mode = &mode_q;
  assign w1c_mode = ~|mode_q;

  always_comb begin
    clr_vec = '0;
    if (cor_mode && strb.rd_cause) clr_vec = clr_vec | cause_q;
    if (w1c_mode && strb.wr_cause) clr_vec = clr_vec | bus_wdata_i;
  end

  irq_cause_bits #(.NBITS(NBITS)) u_cause (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr_vec), .cause_o(cause_q)
  );

  irq_mask_bits #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en_i(strb.wr_mset), .clr_en_i(strb.wr_mclr),
    .wdata_i(bus_wdata_i), .mask_o(mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(cause_q & ~mask_q);
  end

  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(cause_q & ~mask_q))));
  a_r5_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_mode && bus_rd_i && bus_addr_i == ADR_CAUSE && evt_i == '0) |=> (cause_q == '0));
  a_r6_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_mode && !bus_wr_i && evt_i == '0) |=> (cause_q == $past(cause_q)));
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i > ADR_MODE) |-> (bus_rdata_o == '0));
endmodule

// File: tb/irq_cause_bank_tb_top.sv
module irq_cause_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_bank #(.NBITS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // One bus/event cycle: drive at a falling edge, sample read data, release
  task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                     input logic [31:0] d, input logic [31:0] e, output logic [31:0] q);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; evt = e;
    #1 q = rdata;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; evt = '0;
  endtask

  task automatic bwrite(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] q;
    cyc(1'b1, 1'b0, a, d, '0, q);
  endtask

  task automatic bread(input logic [2:0] a, output logic [31:0] q);
    cyc(1'b0, 1'b1, a, '0, '0, q);
  endtask

  task automatic pulse(input logic [31:0] e);
    logic [31:0] q;
    cyc(1'b0, 1'b0, 3'd7, '0, e, q);
  endtask

  task automatic t_reset;
    logic [31:0] q;
    check("R1 irq", {31'b0, irq}, 32'h0);
    bread(3'd0, q); check("R1 cause", q, 32'h0);
    bread(3'd2, q); check("R1 mask", q, ONES);
    bread(3'd5, q); check("R1 mode", q, ONES);
  endtask

  task automatic t_unmapped;
    logic [31:0] q;
    bread(3'd6, q); check("R11 read 6", q, 32'h0);
    bwrite(3'd7, 32'h0);
    bwrite(3'd6, 32'h0);
    bread(3'd7, q); check("R11 read 7", q, 32'h0);
    bread(3'd2, q); check("R11 mask kept", q, ONES);
    bread(3'd5, q); check("R11 mode kept", q, ONES);
  endtask

  task automatic t_masked_event;
    logic [31:0] q;
    pulse(32'h0000_0008);
    bread(3'd1, q); check("R9 masked view", q, 32'h0);
    check("R10 masked no irq", {31'b0, irq}, 32'h0);
    bread(3'd0, q); check("R12 recorded", q, 32'h0000_0008);
    bread(3'd0, q); check("R5 cleared by read", q, 32'h0);
  endtask

  task automatic t_mask_ports;
    logic [31:0] q;
    bwrite(3'd4, 32'h0000_0004);
    bread(3'd2, q); check("R4 clear", q, 32'hFFFF_FFFB);
    bwrite(3'd3, 32'h0000_0004);
    bread(3'd2, q); check("R3 set", q, ONES);
    bwrite(3'd4, 32'h0000_00F0);
    bread(3'd2, q); check("R4 clear field", q, 32'hFFFF_FF0F);
  endtask

  task automatic t_irq;
    logic [31:0] q;
    pulse(32'h0000_0010);
    check("R10 not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R10 raised", {31'b0, irq}, 32'h1);
    bread(3'd1, q); check("R9 masked view", q, 32'h0000_0010);
    bread(3'd1, q); check("R9 no side effect", q, 32'h0000_0010);
    bread(3'd0, q); check("R5 read value", q, 32'h0000_0010);
    check("R10 lag", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R10 dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_cor_write_ignored;
    logic [31:0] q;
    pulse(32'h0000_0200);
    bwrite(3'd0, 32'h0000_0200);
    bread(3'd0, q); check("R5 write ignored", q, 32'h0000_0200);
  endtask

  task automatic t_w1c;
    logic [31:0] q;
    bwrite(3'd5, 32'h0);
    bread(3'd5, q); check("R9 mode readback", q, 32'h0);
    pulse(32'h0000_0030);
    bread(3'd0, q); check("R6 read", q, 32'h0000_0030);
    bread(3'd0, q); check("R6 read keeps", q, 32'h0000_0030);
    bwrite(3'd0, 32'h0000_0010);
    bread(3'd0, q); check("R6 partial clear", q, 32'h0000_0020);
    bwrite(3'd0, 32'h0000_0020);
    bread(3'd0, q); check("R6 all clear", q, 32'h0);
  endtask

  task automatic t_collide_w1c;
    logic [31:0] q;
    pulse(32'h0000_0002);
    cyc(1'b1, 1'b0, 3'd0, 32'h0000_0002, 32'h0000_0002, q);
    bread(3'd0, q); check("R8 w1c collision", q, 32'h0000_0002);
    bwrite(3'd0, 32'h0000_0002);
    bread(3'd0, q); check("R6 clear after collision", q, 32'h0);
  endtask

  task automatic t_other_mode;
    logic [31:0] q;
    bwrite(3'd5, 32'h0000_0005);
    pulse(32'h0000_0001);
    bread(3'd0, q); check("R7 read", q, 32'h0000_0001);
    bread(3'd0, q); check("R7 read keeps", q, 32'h0000_0001);
    bwrite(3'd0, 32'h0000_0001);
    bread(3'd0, q); check("R7 write keeps", q, 32'h0000_0001);
    bwrite(3'd5, ONES);
    bread(3'd0, q); check("R5 back to cor", q, 32'h0000_0001);
    bread(3'd0, q); check("R5 cleared", q, 32'h0);
  endtask

  task automatic t_collide_cor;
    logic [31:0] q;
    pulse(32'h0000_0080);
    cyc(1'b0, 1'b1, 3'd0, '0, 32'h0000_0080, q);
    check("R8 cor read value", q, 32'h0000_0080);
    bread(3'd0, q); check("R8 cor collision", q, 32'h0000_0080);
    bread(3'd0, q); check("R5 cleared after collision", q, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_unmapped();
    t_masked_event();
    t_mask_ports();
    t_irq();
    t_cor_write_ignored();
    t_w1c();
    t_collide_w1c();
    t_other_mode();
    t_collide_cor();
    bwrite(3'd3, ONES);
    begin
      logic [31:0] q;
      bread(3'd2, q); check("R3 mask all", q, ONES);
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule